// File: doc/BRIEF.md
# SD Card SPI-Mode Target Emulator

This block plays the card side of an SD card operating in SPI mode, as seen through a byte-wide port interface. A host controller writes command and data bytes to a data port and reads response bytes back through the same port. A separate select port sets an active-low chip select. Bit serialisation, CRC checking and multi-block transfers are not part of the block.

Commands arrive as six-byte frames. An input state machine collects each frame and decodes it. It also handles the application-command prefix and the start-token handshake that comes before a written block. A separate output machine plays back the response byte by byte as the host reads. The block supports the reset and initialisation sequence, a status query, single-block reads and single-block writes of 512 bytes. The backing store is a small internal memory made of `NUM_BLOCKS` blocks, and block data is addressed in bytes.

Top module: `sd_spi_target`

## Requirements
- R1: A write on the select port loads bit 0 as the chip-select level, where 1 means deselected, and the block is deselected after reset. Writing a 1 clears the application-command flag, returns the command machine to idle and discards any response not yet read.
- R2: While the block is deselected, data-port writes have no effect and data-port reads return 0xFF. While selected with no response pending, reads also return 0xFF.
- R3: In idle, a written byte starts a command only if bits 7:6 are 01. Bits 5:0 give the command index. Five more bytes follow: four argument bytes, most significant first, then a check byte. Other bytes written in idle are ignored.
- R4: A command runs on the data-port write that follows its sixth byte, and the value of that write is discarded. The base R1 value is 0x04 (illegal-command bit 2) when bit 0 of the check byte is 0, and 0x00 otherwise.
- R5: Index 0 answers the base R1 with bit 0 (idle) set. Index 55 answers the same way and marks the next command as an application command.
- R6: Application command 41 answers the base R1. The application flag applies to exactly one command. Index 8, index 41 without the prefix, and every other index answer the base R1 with bit 2 set.
- R7: Index 13 answers two bytes, 0x00 then 0x00.
- R8: Index 17 with a valid address answers, in order: the base R1, 0xFF, 0xFF, the token 0xFE, the 512 stored bytes starting at the argument's byte address, 0xFF and 0xFF. After the last response byte, reads return 0xFF.
- R9: An address is valid only if it is a multiple of 512 and lies below NUM_BLOCKS*512. Index 17 with an invalid address answers only the base R1 with bit 2 set.
- R10: Index 24 answers the base R1. Data bytes other than 0xFE are then ignored until 0xFE arrives. The next 512 bytes are stored at the addressed block, and the response becomes the single byte 0x05.
- R11: Index 24 with an invalid address still answers the base R1 and accepts the token and 512 bytes. It leaves the memory unchanged and then answers 0x0B.
- R12: The read-data output is registered. It reset to 0xFF, takes a new value on the clock edge at which a read strobe is sampled, and holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| sel_wr | input | 1 | Select-port write strobe (bit 0 of wdata is the chip-select level) |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Registered data-port read byte |

## Verification
The bench goes after the following corner cases.

- Command timing: it checks that a response appears only after the extra write that follows the sixth byte. A design that ran the command on the sixth byte would return R1 where 0xFF is expected.
- Application prefix: it checks that the prefix is consumed by one command and is lost when the card is deselected. A design that kept the flag would answer 0x00 where the illegal code 0x04 is expected.
- Address checks: it uses unaligned and out-of-range addresses for both reads and writes. An invalid write that still reached memory would show up as corrupted bytes when the block is read back later. It also checks that junk bytes before the start token are not stored, which would shift the stored block by one.
- Read-data latency: a read stream of full length compares each of the 518 bytes. An error of one byte in the prefetch of the synchronous memory would show up as every data byte being shifted.

// File: rtl/sd_tgt_pkg.sv
package sd_tgt_pkg;
  localparam int unsigned BLK_BYTES = 512;
  localparam int unsigned OFF_W     = 9;

  localparam logic [7:0] R1_IDLE    = 8'h01;
  localparam logic [7:0] R1_ILLEGAL = 8'h04;
  localparam logic [7:0] TOK_START  = 8'hFE;
  localparam logic [7:0] DRSP_OK    = 8'h05;
  localparam logic [7:0] DRSP_ERR   = 8'h0B;
  localparam logic [7:0] FILL       = 8'hFF;

  typedef enum logic [1:0] {RX_IDLE, RX_CMD, RX_SBLK, RX_WBLK} rx_st_t;
  typedef enum logic [1:0] {RK_NONE, RK_BYTE, RK_PAIR, RK_READ} rsp_kind_t;
endpackage

// File: rtl/sd_blk_ram.sv
module sd_blk_ram #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_tgt_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int BLK_W      = 2,
  parameter int ADDR_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [7:0]        wbyte,
  output logic              rsp_start,
  output rsp_kind_t         rsp_kind,
  output logic [7:0]        rsp_byte0,
  output logic [BLK_W-1:0]  rsp_blk,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int HI_W = 32 - OFF_W;

  rx_st_t            st;
  logic [5:0]        cmd_q;
  logic [31:0]       arg_q;
  logic              crc0_q;
  logic [2:0]        nbyte;
  logic [OFF_W-1:0]  wcnt;
  logic              app_q;
  logic [BLK_W-1:0]  wblk_q;
  logic              wok_q;

  logic              exec, blk_end, addr_ok;
  logic [6:0]        code;
  logic [7:0]        r1_base;
  rsp_kind_t         dec_kind;
  logic [7:0]        dec_b0;
  rx_st_t            dec_next;
  logic              dec_app;

  assign exec    = wr && (st == RX_CMD) && (nbyte == 3'd6);
  assign blk_end = wr && (st == RX_WBLK) && (wcnt == {OFF_W{1'b1}});
  assign code    = {app_q, cmd_q};
  assign r1_base = crc0_q ? 8'h00 : R1_ILLEGAL;
  assign addr_ok = (arg_q[OFF_W-1:0] == '0) &&
                   (arg_q[31:OFF_W] < HI_W'(NUM_BLOCKS));

  always_comb begin
    dec_kind = RK_BYTE;
    dec_b0   = r1_base | R1_ILLEGAL;
    dec_next = RX_IDLE;
    dec_app  = 1'b0;
    case (code)
      7'd0:   dec_b0 = r1_base | R1_IDLE;
      7'd55: begin
        dec_b0  = r1_base | R1_IDLE;
        dec_app = 1'b1;
      end
      7'd105: dec_b0 = r1_base;             // prefixed index 41
      7'd13: begin
        dec_kind = RK_PAIR;
        dec_b0   = 8'h00;
      end
      7'd17: begin
        if (addr_ok) begin
          dec_kind = RK_READ;
          dec_b0   = r1_base;
        end
      end
      7'd24: begin
        dec_b0   = r1_base;
        dec_next = RX_SBLK;
      end
      default: ;
    endcase
  end

  assign rsp_start = exec || blk_end;
  assign rsp_kind  = blk_end ? RK_BYTE : dec_kind;
  assign rsp_byte0 = blk_end ? (wok_q ? DRSP_OK : DRSP_ERR) : dec_b0;
  assign rsp_blk   = arg_q[OFF_W +: BLK_W];

  assign mem_we    = wr && (st == RX_WBLK) && wok_q;
  assign mem_waddr = {wblk_q, wcnt};
  assign mem_wdata = wbyte;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st     <= RX_IDLE;
      cmd_q  <= '0;
      arg_q  <= '0;
      crc0_q <= 1'b0;
      nbyte  <= '0;
      wcnt   <= '0;
      app_q  <= 1'b0;
      wblk_q <= '0;
      wok_q  <= 1'b0;
    end else if (wr) begin
      case (st)
        RX_IDLE: begin
          if (wbyte[7:6] == 2'b01) begin
            cmd_q <= wbyte[5:0];
            nbyte <= 3'd1;
            st    <= RX_CMD;
          end
        end
        RX_CMD: begin
          if (nbyte != 3'd6) begin
            if (nbyte <= 3'd4) arg_q <= {arg_q[23:0], wbyte};
            else               crc0_q <= wbyte[0];
            nbyte <= nbyte + 3'd1;
          end else begin
            st    <= dec_next;
            app_q <= dec_app;
            if (dec_next == RX_SBLK) begin
              wblk_q <= arg_q[OFF_W +: BLK_W];
              wok_q  <= addr_ok;
            end
          end
        end
        RX_SBLK: begin
          if (wbyte == TOK_START) begin
            st   <= RX_WBLK;
            wcnt <= '0;
          end
        end
        RX_WBLK: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == {OFF_W{1'b1}}) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R1
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (st == RX_IDLE && !app_q));

  // R3
  cmd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !flush && st == RX_IDLE) |=> ((st == RX_CMD) == ($past(wbyte[7:6]) == 2'b01)));

  // R10
  token_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !flush && st == RX_SBLK && wbyte != TOK_START) |=> (st == RX_SBLK));
endmodule

// File: rtl/sd_rsp_tx.sv
module sd_rsp_tx
  import sd_tgt_pkg::*;
#(
  parameter int BLK_W  = 2,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  rsp_kind_t         kind,
  input  logic [7:0]        byte0,
  input  logic [BLK_W-1:0]  blk,
  input  logic              rd,
  input  logic [7:0]        mem_q,
  output logic [7:0]        rbyte,
  output logic [ADDR_W-1:0] raddr
);
  localparam logic [9:0] HDR_LEN = 10'd4;
  localparam logic [9:0] RD_LEN  = HDR_LEN + 10'(BLK_BYTES) + 10'd2;
  localparam logic [9:0] DAT_END = HDR_LEN + 10'(BLK_BYTES);

  rsp_kind_t        kind_q, kind_n;
  logic [9:0]       idx_q, idx_n, len_q;
  logic [7:0]       b0_q, b0_n;
  logic [BLK_W-1:0] blk_q, blk_n;
  logic [9:0]       off_n;

  always_comb begin
    case (kind_q)
      RK_BYTE: len_q = 10'd1;
      RK_PAIR: len_q = 10'd2;
      RK_READ: len_q = RD_LEN;
      default: len_q = 10'd0;
    endcase
  end

  always_comb begin
    kind_n = kind_q;
    idx_n  = idx_q;
    b0_n   = b0_q;
    blk_n  = blk_q;
    if (flush) begin
      kind_n = RK_NONE;
      idx_n  = '0;
    end else if (start) begin
      kind_n = kind;
      idx_n  = '0;
      b0_n   = byte0;
      blk_n  = blk;
    end else if (rd && kind_q != RK_NONE) begin
      if (idx_q + 10'd1 == len_q) begin
        kind_n = RK_NONE;
        idx_n  = '0;
      end else begin
        idx_n = idx_q + 10'd1;
      end
    end
  end

  // prefetch: address the memory with the index that will be current next cycle
  assign off_n = idx_n - HDR_LEN;
  assign raddr = {blk_n, off_n[OFF_W-1:0]};

  always_comb begin
    rbyte = FILL;
    if (kind_q != RK_NONE) begin
      if (idx_q == 10'd0)           rbyte = b0_q;
      else if (kind_q == RK_PAIR)   rbyte = 8'h00;
      else if (kind_q == RK_READ) begin
        if (idx_q == HDR_LEN - 10'd1)                    rbyte = TOK_START;
        else if (idx_q >= HDR_LEN && idx_q < DAT_END)    rbyte = mem_q;
        else                                             rbyte = FILL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= RK_NONE;
      idx_q  <= '0;
      b0_q   <= FILL;
      blk_q  <= '0;
    end else begin
      kind_q <= kind_n;
      idx_q  <= idx_n;
      b0_q   <= b0_n;
      blk_q  <= blk_n;
    end
  end

  // R8
  read_len_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_q == RK_READ) |-> (idx_q < RD_LEN));

  // R7
  pair_len_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_q == RK_PAIR) |-> (idx_q < 10'd2));
endmodule

// File: rtl/sd_spi_target.sv
module sd_spi_target
  import sd_tgt_pkg::*;
#(
  parameter int NUM_BLOCKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic       sel_wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int ADDR_W = BLK_W + OFF_W;
  localparam int DEPTH  = (1 << BLK_W) * BLK_BYTES;

  logic              cs_n;
  logic              flush, wr_ok, rd_ok;
  logic              rsp_start;
  rsp_kind_t         rsp_kind;
  logic [7:0]        rsp_byte0, rbyte, mem_q, mem_wdata;
  logic [BLK_W-1:0]  rsp_blk;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  assign flush = sel_wr && wdata[0];
  assign wr_ok = dat_wr && !cs_n;
  assign rd_ok = dat_rd && !cs_n;

  always_ff @(posedge clk) begin
    if (rst)         cs_n <= 1'b1;
    else if (sel_wr) cs_n <= wdata[0];
  end

  sd_cmd_rx #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst(rst), .flush(flush), .wr(wr_ok), .wbyte(wdata),
    .rsp_start(rsp_start), .rsp_kind(rsp_kind), .rsp_byte0(rsp_byte0),
    .rsp_blk(rsp_blk), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  sd_rsp_tx #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst(rst), .flush(flush), .start(rsp_start), .kind(rsp_kind),
    .byte0(rsp_byte0), .blk(rsp_blk), .rd(rd_ok), .mem_q(mem_q),
    .rbyte(rbyte), .raddr(mem_raddr)
  );

  sd_blk_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata <= FILL;
    else if (dat_rd) rdata <= cs_n ? FILL : rbyte;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dat_rd |=> $stable(rdata));

  // R2
  desel_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && cs_n) |=> (rdata == FILL));
endmodule

// File: tb/sd_spi_target_tb.sv
module sd_spi_target_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, dat_wr = 1'b0, dat_rd = 1'b0, sel_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  sd_spi_target #(.NUM_BLOCKS(4)) u_dut (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .sel_wr(sel_wr), .wdata(wdata), .rdata(rdata)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R12";
  bit    chk_on = 0, done = 0;
  logic [7:0] exp_rd = 8'hFF;

  // reference model state
  int mq[$];
  bit m_cs_n = 1, m_app = 0, m_wok = 0;
  int m_st = 0, m_cmd = 0, m_cnt = 0, m_arg = 0, m_crc = 0, m_blk = 0, m_wc = 0;
  int m_mem [0:2047];

  function automatic bit m_ok(int a);
    return (a % 512 == 0) && (a >= 0) && (a < 4 * 512);
  endfunction

  task automatic m_exec();
    int r1, code;
    r1 = (m_crc & 1) ? 0 : 4;
    code = m_cmd + (m_app ? 64 : 0);
    m_app = 0;
    m_st = 0;
    mq.delete();
    case (code)
      0:   mq.push_back(r1 | 1);
      55: begin mq.push_back(r1 | 1); m_app = 1; end
      105: mq.push_back(r1);
      13: begin mq.push_back(0); mq.push_back(0); end
      17: begin
        if (m_ok(m_arg)) begin
          mq.push_back(r1); mq.push_back(255); mq.push_back(255); mq.push_back(254);
          for (int i = 0; i < 512; i++) mq.push_back(m_mem[m_arg + i]);
          mq.push_back(255); mq.push_back(255);
        end else mq.push_back(r1 | 4);
      end
      24: begin
        mq.push_back(r1);
        m_st = 2;
        m_wok = m_ok(m_arg);
        m_blk = m_arg;
      end
      default: mq.push_back(r1 | 4);
    endcase
  endtask

  task automatic m_write(int b);
    if (m_cs_n) return;
    case (m_st)
      0: if ((b & 8'hC0) == 8'h40) begin m_cmd = b & 8'h3F; m_cnt = 1; m_st = 1; end
      1: begin
        if (m_cnt < 6) begin
          if (m_cnt <= 4) m_arg = (m_arg << 8) | b;
          else m_crc = b;
          m_cnt++;
        end else m_exec();
      end
      2: if (b == 8'hFE) begin m_st = 3; m_wc = 0; end
      default: begin
        if (m_wok) m_mem[m_blk + m_wc] = b;
        m_wc++;
        if (m_wc == 512) begin
          mq.delete();
          mq.push_back(m_wok ? 8'h05 : 8'h0B);
          m_st = 0;
        end
      end
    endcase
  endtask

  // compare the design against the model after every clock edge
  always @(posedge clk) begin
    #2;
    if (chk_on) begin
      checks++;
      if (rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s rdata actual=%02h expected=%02h", cur_req, rdata, exp_rd);
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic dwr(int b);
    @(negedge clk);
    dat_wr = 1'b1; wdata = 8'(b);
    m_write(b);
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic drd(output logic [7:0] got);
    @(negedge clk);
    dat_rd = 1'b1;
    if (m_cs_n || mq.size() == 0) exp_rd = 8'hFF;
    else exp_rd = 8'(mq.pop_front());
    @(negedge clk);
    dat_rd = 1'b0;
    got = rdata;
  endtask

  task automatic sel(int b);
    @(negedge clk);
    sel_wr = 1'b1; wdata = 8'(b);
    m_cs_n = b[0];
    if (m_cs_n) begin m_app = 0; m_st = 0; mq.delete(); end
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic frame(int idx, int arg, int crc);
    dwr(8'h40 | idx);
    dwr((arg >> 24) & 255); dwr((arg >> 16) & 255);
    dwr((arg >> 8) & 255);  dwr(arg & 255);
    dwr(crc);
  endtask

  task automatic cmd(int idx, int arg, int crc);
    frame(idx, arg, crc);
    dwr(8'hFF);
  endtask

  task automatic rd_n(int n, output logic [7:0] last);
    logic [7:0] g;
    g = 8'hFF;
    for (int i = 0; i < n; i++) drd(g);
    last = g;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    logic [7:0] g;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;
    chk("R12", rdata, 8'hFF);

    // R2: writes and reads while deselected
    cur_req = "R2";
    cmd(0, 0, 8'h95);
    drd(g); chk("R2", g, 8'hFF);
    sel(0);
    drd(g); chk("R2", g, 8'hFF);

    // R3: junk bytes in idle, then reset command
    cur_req = "R3";
    dwr(8'hFF); dwr(8'h00); dwr(8'h80); dwr(8'hC0);
    drd(g); chk("R3", g, 8'hFF);
    cur_req = "R5";
    cmd(0, 0, 8'h95);
    drd(g); chk("R5", g, 8'h01);
    drd(g); chk("R2", g, 8'hFF);

    // R4: check-byte bit 0 clear, and run on the extra write
    cur_req = "R4";
    cmd(0, 0, 8'h94);
    drd(g); chk("R4", g, 8'h05);
    frame(13, 0, 8'h01);
    drd(g); chk("R4", g, 8'hFF);
    dwr(8'hFF);
    cur_req = "R7";
    drd(g); chk("R7", g, 8'h00);
    drd(g); chk("R7", g, 8'h00);
    drd(g); chk("R7", g, 8'hFF);

    // R6: application prefix
    cur_req = "R6";
    cmd(41, 0, 8'h01);
    drd(g); chk("R6", g, 8'h04);
    cmd(55, 0, 8'h01);
    drd(g); chk("R5", g, 8'h01);
    cmd(41, 32'h40000000, 8'h01);
    drd(g); chk("R6", g, 8'h00);
    cmd(41, 0, 8'h01);
    drd(g); chk("R6", g, 8'h04);
    cmd(8, 32'h1AA, 8'h87);
    drd(g); chk("R6", g, 8'h04);
    cmd(55, 0, 8'h01);
    cmd(0, 0, 8'h01);
    drd(g); chk("R6", g, 8'h04);

    // R10: block write with junk before the token
    cur_req = "R10";
    cmd(24, 32'h200, 8'h01);
    drd(g); chk("R10", g, 8'h00);
    dwr(8'hFF); dwr(8'h12); dwr(8'hFE);
    for (int i = 0; i < 512; i++) dwr((i * 7 + 3) & 255);
    drd(g); chk("R10", g, 8'h05);

    // R8: read back the written block
    cur_req = "R8";
    cmd(17, 32'h200, 8'h01);
    drd(g); chk("R8", g, 8'h00);
    drd(g); chk("R8", g, 8'hFF);
    drd(g); chk("R8", g, 8'hFF);
    drd(g); chk("R8", g, 8'hFE);
    drd(g); chk("R8", g, 8'h03);
    rd_n(511, g); chk("R8", g, 8'((511 * 7 + 3) & 255));
    rd_n(2, g); chk("R8", g, 8'hFF);
    drd(g); chk("R8", g, 8'hFF);

    // R9: invalid read addresses
    cur_req = "R9";
    cmd(17, 32'h201, 8'h01);
    drd(g); chk("R9", g, 8'h04);
    drd(g); chk("R9", g, 8'hFF);
    cmd(17, 32'h800, 8'h01);
    drd(g); chk("R9", g, 8'h04);

    // R11: valid write, then an invalid write that must not land
    cur_req = "R11";
    cmd(24, 32'h400, 8'h01);
    drd(g);
    dwr(8'hFE);
    for (int i = 0; i < 512; i++) dwr(i ^ 8'h5A);
    drd(g); chk("R10", g, 8'h05);
    cmd(24, 32'h401, 8'h01);
    drd(g); chk("R11", g, 8'h00);
    dwr(8'hFE);
    for (int i = 0; i < 512; i++) dwr(8'hC3);
    drd(g); chk("R11", g, 8'h0B);
    cmd(17, 32'h400, 8'h01);
    rd_n(5, g); chk("R11", g, 8'h5A);
    rd_n(513, g); chk("R11", g, 8'hFF);

    // R1: deselect drops a response, the prefix and a partial frame
    cur_req = "R1";
    cmd(17, 32'h200, 8'h01);
    rd_n(3, g);
    sel(1); sel(0);
    drd(g); chk("R1", g, 8'hFF);
    cmd(55, 0, 8'h01);
    sel(1); sel(0);
    cmd(41, 0, 8'h01);
    drd(g); chk("R1", g, 8'h04);
    dwr(8'h4D); dwr(8'h00);
    sel(1); sel(0);
    cmd(13, 0, 8'h01);
    drd(g); chk("R1", g, 8'h00);
    drd(g); chk("R1", g, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule